// File: doc/BRIEF.md
# Cartridge Bus Read Responder

This block answers 16-bit read cycles that a console makes on its cartridge port. It runs in a fast local clock domain, nominally 100 MHz. The cartridge strobe, the console reset, the presence sense and the word address are all asynchronous to that clock, so each one passes through a chain of flip-flops before any logic uses it. When a read cycle starts, the block decodes the word address. A small window at the bottom of the address space is served from a boot image held in logic. Every other address becomes a single request on an external word-memory port, which has a busy/valid handshake.

The boot image holds a reset vector pair and a short loop program. It also holds the four-character ASCII signature that the console looks for at byte offset 0x100. With this image the console can run a diagnostic program even when the external memory is not working. The answered word is held on the local data output and its pad enable for as long as the strobe stays low. The output is released once the strobe rises. The block also drives the external bus transceiver: an active-low enable and a direction line.

Top module: `cartrom_responder`

## Requirements
- R1: The cartridge address input is a word address because the bus has no byte line A0, so byte offset N is word N/2. Each external request presents exactly the captured word address on `mem_addr`.
- R2: A read cycle starts only when the synchronised strobe is low, the synchronised console reset is high (inactive) and the cartridge is present. Otherwise no data is driven and no memory request is made.
- R3: Word addresses 0x000000 to 0x000081 are answered from the boot image and never cause a memory request. Every word address from 0x000082 upward is fetched from the memory port.
- R4: Boot image word 0x80 reads 0x5345 and word 0x81 reads 0x4741, which is the ASCII signature at byte offset 0x100.
- R5: Boot image words 0 to 3 read 0x0000, 0x0000, 0x0000, 0x0008 (stack pointer 0, start address 8). Words 4 to 8 read 0x41F8, 0x0100, 0x4CD8, 0x000F, 0x60F6. All other words below 0x80 read 0x0000.
- R6: A boot image hit drives valid data no later than 6 clock cycles after the strobe falls, with every input passing through two synchronising flip-flops.
- R7: The answered word stays driven and does not change while the strobe is low. The pad enable `data_drive` falls within 3 cycles of the strobe rising.
- R8: The active-low transceiver enable is asserted only while the cartridge is present and the synchronised strobe is low. The direction output is always 1 (toward the console). The pad enable is never high while the transceiver enable is inactive.
- R9: `mem_req` is a one-cycle pulse, raised only when `mem_busy` was low in the cycle before. Read data is taken from `mem_rdata` on the `mem_valid` pulse.
- R10: Each strobe low period makes at most one memory request, even when the strobe rises before the data returns. No new cycle starts until the strobe has been seen high.
- R11: With a memory that answers 3 cycles after its request, an external read drives valid data no later than 15 cycles after the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| cart_present | input | 1 | Console powered sense, high when present |
| cart_rst_n | input | 1 | Console reset, active low, asynchronous |
| cart_rd_n | input | 1 | Cartridge read strobe, active low, asynchronous |
| cart_addr | input | 22 | Cartridge word address (byte lines 1 to 22) |
| xcvr_oe_n | output | 1 | Data transceiver enable, active low |
| xcvr_dir | output | 1 | Data transceiver direction, 1 = toward console |
| data_out | output | 16 | Word presented to the data pads |
| data_drive | output | 1 | Data pad output enable, pads tri-stated when low |
| mem_req | output | 1 | One-cycle read request to the word memory |
| mem_addr | output | 22 | Word address of the request |
| mem_busy | input | 1 | Memory port cannot accept a request |
| mem_valid | input | 1 | One-cycle pulse, `mem_rdata` valid |
| mem_rdata | input | 16 | Returned memory word |

## Verification
The bench builds the block with its default parameters: a 22-bit address, two synchroniser stages and the signature at word 0x80. With these values the whole boot window plus both signature words can be read one word at a time, and the window edge at 0x81/0x82 falls inside a dense sweep of external addresses. A memory model with fixed latency plus a busy line the bench can force lets the bench check request gating and the one-access rule. Further cases cover a strobe released before the data returns, console reset held active, and the cartridge absent.

// File: rtl/cartrom_pkg.sv
package cartrom_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;

  // Boot image contents; idx is the word index inside the window,
  // sig the word index of the first signature word.
  function automatic logic [WORD_W-1:0] boot_word(input logic [7:0] idx,
                                                  input logic [7:0] sig);
    logic [WORD_W-1:0] w;
    if (idx == sig) begin
      w = 16'h5345;
    end else if (idx == sig + 8'd1) begin
      w = 16'h4741;
    end else begin
      case (idx)
        8'd3:    w = 16'h0008;   // start address low half
        8'd4:    w = 16'h41F8;   // load 0x0100 into a0
        8'd5:    w = 16'h0100;
        8'd6:    w = 16'h4CD8;   // four longwords post-increment
        8'd7:    w = 16'h000F;
        8'd8:    w = 16'h60F6;   // short branch back to word 4
        default: w = '0;
      endcase
    end
    return w;
  endfunction

  // Window test: word addresses below the limit come from the boot image
  function automatic logic in_window(input logic [31:0] addr,
                                     input logic [31:0] limit);
    return addr < limit;
  endfunction

endpackage

// File: rtl/cartrom_sync.sv
module cartrom_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) chain_q[i] <= INIT;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < N; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[N-1];
endmodule

// File: rtl/cartrom_bootrom.sv
module cartrom_bootrom
  import cartrom_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int SIG_WORD = 128
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [WORD_W-1:0] word
);
  localparam logic [31:0] LIMIT = 32'(SIG_WORD + 2);
  localparam logic [7:0]  SIG8  = 8'(SIG_WORD);

  logic [31:0] addr_wide;
  assign addr_wide = 32'(addr);

  assign hit  = in_window(addr_wide, LIMIT);
  assign word = hit ? boot_word(addr_wide[7:0], SIG8) : '0;
endmodule

// File: rtl/cartrom_seq.sv
module cartrom_seq
  import cartrom_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_ok,
  input  logic              strobe_low,
  input  logic              rom_hit,
  input  logic [WORD_W-1:0] rom_word,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mem_busy,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] hold_data,
  output logic              holding,
  output logic              start_evt,
  output logic              fill_evt,
  output logic              release_evt
);
  seq_state_e        state_q;
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  assign start_evt   = (state_q == ST_IDLE)  && cycle_ok;
  assign fill_evt    = (state_q == ST_FETCH) && mem_valid;
  assign release_evt = (state_q == ST_HOLD)  && !strobe_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      req_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_evt) begin
            addr_q <= addr_in;
            if (rom_hit) begin
              data_q  <= rom_word;
              state_q <= ST_HOLD;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (!mem_busy) begin
            req_q   <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fill_evt) begin
            data_q  <= mem_rdata;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (release_evt) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = req_q;
  assign mem_addr  = addr_q;
  assign hold_data = data_q;
  assign holding   = (state_q == ST_HOLD);
endmodule

// File: rtl/cartrom_responder.sv
module cartrom_responder
  import cartrom_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int SYNC_STAGES = 2,
  parameter int SIG_WORD = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cart_present,
  input  logic              cart_rst_n,
  input  logic              cart_rd_n,
  input  logic [ADDR_W-1:0] cart_addr,
  output logic              xcvr_oe_n,
  output logic              xcvr_dir,
  output logic [WORD_W-1:0] data_out,
  output logic              data_drive,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_busy,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int BUS_W = ADDR_W + 3;
  // idle values: absent, console in reset, strobe high, address zero
  localparam logic [BUS_W-1:0] BUS_INIT = {1'b0, 1'b0, 1'b1, {ADDR_W{1'b0}}};

  logic [BUS_W-1:0]  bus_raw, bus_s;
  logic              present_s, crst_n_s, rd_n_s;
  logic [ADDR_W-1:0] addr_s;

  assign bus_raw = {cart_present, cart_rst_n, cart_rd_n, cart_addr};

  cartrom_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .INIT(BUS_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign {present_s, crst_n_s, rd_n_s, addr_s} = bus_s;

  logic strobe_low, cycle_ok;
  assign strobe_low = !rd_n_s;
  assign cycle_ok   = strobe_low && crst_n_s && present_s;

  logic              rom_hit;
  logic [WORD_W-1:0] rom_word;

  cartrom_bootrom #(.ADDR_W(ADDR_W), .SIG_WORD(SIG_WORD)) u_rom (
    .addr(addr_s), .hit(rom_hit), .word(rom_word)
  );

  logic              holding, start_evt, fill_evt, release_evt;
  logic [WORD_W-1:0] hold_data;

  cartrom_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cycle_ok(cycle_ok), .strobe_low(strobe_low),
    .rom_hit(rom_hit), .rom_word(rom_word), .addr_in(addr_s),
    .mem_busy(mem_busy), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .hold_data(hold_data), .holding(holding),
    .start_evt(start_evt), .fill_evt(fill_evt), .release_evt(release_evt)
  );

  logic bus_window;
  assign bus_window = present_s && strobe_low;

  assign xcvr_oe_n  = !bus_window;
  assign xcvr_dir   = 1'b1;
  assign data_drive = holding && bus_window;
  assign data_out   = hold_data;
endmodule

// File: rtl/cartrom_responder_chk.sv
module cartrom_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_busy,
  input logic        data_drive,
  input logic        xcvr_oe_n,
  input logic [15:0] data_out,
  input logic        start_evt,
  input logic        rom_hit
);
  logic [1:0] reqs_seen;
  logic       rom_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqs_seen <= '0;
      rom_cycle <= 1'b0;
    end else if (start_evt) begin
      reqs_seen <= '0;
      rom_cycle <= rom_hit;
    end else if (mem_req && reqs_seen != 2'd3) begin
      reqs_seen <= reqs_seen + 2'd1;
    end
  end

  // R9
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(!mem_busy));

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R8
  drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_drive |-> !xcvr_oe_n);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_drive && $past(data_drive)) |-> $stable(data_out));

  // R10
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (reqs_seen == 2'd0));

  // R3
  rom_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rom_cycle);
endmodule

bind cartrom_responder cartrom_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_busy(mem_busy),
  .data_drive(data_drive), .xcvr_oe_n(xcvr_oe_n), .data_out(data_out),
  .start_evt(start_evt), .rom_hit(rom_hit)
);

// File: tb/cartrom_responder_test.sv
module cartrom_responder_test;
  localparam int PERIOD = 10;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cart_present = 1'b1;
  logic        cart_rst_n = 1'b1;
  logic        cart_rd_n = 1'b1;
  logic [21:0] cart_addr = '0;
  logic        xcvr_oe_n, xcvr_dir, data_drive, mem_req;
  logic [15:0] data_out;
  logic [21:0] mem_addr;
  logic        mem_busy;
  logic        mem_valid = 1'b0;
  logic [15:0] mem_rdata = '0;

  logic        busy_force = 1'b0;
  logic        busy_m = 1'b0;
  int          cnt = 0;
  logic [21:0] pend_addr = '0;
  int          req_total = 0;
  logic [21:0] last_req_addr = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cartrom_responder uut (
    .clk(clk), .rst_n(rst_n), .cart_present(cart_present),
    .cart_rst_n(cart_rst_n), .cart_rd_n(cart_rd_n), .cart_addr(cart_addr),
    .xcvr_oe_n(xcvr_oe_n), .xcvr_dir(xcvr_dir), .data_out(data_out),
    .data_drive(data_drive), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_busy(mem_busy), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] ext_word(input logic [21:0] a);
    return a[15:0] ^ 16'hC3A5 ^ {10'b0, a[21:16]};
  endfunction

  // expected boot image, indexed by byte offset
  function automatic logic [15:0] exp_boot(input int word_idx);
    int boff;
    boff = word_idx * 2;
    if (boff == 16'h100) return 16'h5345;   // "SE"
    if (boff == 16'h102) return 16'h4741;   // "GA"
    if (boff == 6)  return 16'h0008;
    if (boff == 8)  return 16'h41F8;
    if (boff == 10) return 16'h0100;
    if (boff == 12) return 16'h4CD8;
    if (boff == 14) return 16'h000F;
    if (boff == 16) return 16'h60F6;
    return 16'h0000;
  endfunction

  assign mem_busy = busy_m | busy_force;

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req) begin
      req_total = req_total + 1;
      last_req_addr = mem_addr;
    end
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_valid <= 1'b1;
        mem_rdata <= ext_word(pend_addr);
        busy_m    <= 1'b0;
      end
    end else if (mem_req) begin
      busy_m    <= 1'b1;
      cnt       <= LAT;
      pend_addr <= mem_addr;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [21:0] a, input logic [15:0] exp,
                         input bit is_rom, input string tag);
    int lat;
    int base;
    base = req_total;
    cart_addr = a;
    @(negedge clk);
    cart_rd_n = 1'b0;
    lat = 0;
    while (!data_drive && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(data_drive == 1'b1, "R7 drive", 32'(data_drive), 1);
    check(data_out == exp, tag, 32'(data_out), 32'(exp));
    check(!xcvr_oe_n && xcvr_dir, "R8 oe/dir", {30'b0, xcvr_oe_n, xcvr_dir}, 1);
    if (is_rom) check(lat <= 6, "R6 latency", lat, 6);
    else        check(lat <= 15, "R11 latency", lat, 15);
    repeat (3) @(negedge clk);
    check(data_drive && data_out == exp, "R7 hold", 32'(data_out), 32'(exp));
    cart_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!data_drive && xcvr_oe_n, "R7 release", {30'b0, data_drive, xcvr_oe_n}, 1);
    check(req_total - base == (is_rom ? 0 : 1), "R10 req count",
          req_total - base, is_rom ? 0 : 1);
    if (!is_rom) check(last_req_addr == a, "R1 addr", 32'(last_req_addr), 32'(a));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(xcvr_oe_n && !data_drive && !mem_req && xcvr_dir, "R8 reset state",
          {28'b0, xcvr_oe_n, data_drive, mem_req, xcvr_dir}, 32'h9);

    // full boot window, including both signature words
    for (int i = 0; i < 130; i++) begin
      do_read(22'(i), exp_boot(i), 1'b1,
              (i >= 128) ? "R4 signature" : (i <= 8) ? "R5 vectors" : "R3 window");
    end

    // external space from the window edge upward
    for (int i = 130; i < 386; i++) begin
      do_read(22'(i), ext_word(22'(i)), 1'b0, "R3 external");
    end
    do_read(22'h3FFFFF, ext_word(22'h3FFFFF), 1'b0, "R1 top word");
    do_read(22'h2AAAAA, ext_word(22'h2AAAAA), 1'b0, "R1 pattern");

    // console reset held: no cycle
    base = req_total;
    cart_rst_n = 1'b0;
    cart_addr = 22'h000200;
    @(negedge clk);
    cart_rd_n = 1'b0;
    repeat (12) @(negedge clk);
    check(!data_drive && req_total == base, "R2 console reset",
          {31'b0, data_drive}, 0);
    cart_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cart_rst_n = 1'b1;

    // cartridge absent: transceiver stays off
    cart_present = 1'b0;
    @(negedge clk);
    cart_rd_n = 1'b0;
    repeat (12) @(negedge clk);
    check(xcvr_oe_n && !data_drive && req_total == base, "R2 absent",
          {30'b0, xcvr_oe_n, data_drive}, 2);
    cart_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cart_present = 1'b1;
    repeat (4) @(negedge clk);

    // memory busy: request waits
    busy_force = 1'b1;
    cart_addr = 22'h001234;
    @(negedge clk);
    cart_rd_n = 1'b0;
    repeat (12) @(negedge clk);
    check(req_total == base && !data_drive, "R9 busy gate", req_total - base, 0);
    busy_force = 1'b0;
    repeat (10) @(negedge clk);
    check(req_total == base + 1 && data_drive, "R9 after busy",
          req_total - base, 1);
    check(data_out == ext_word(22'h001234), "R9 data latched",
          32'(data_out), 32'(ext_word(22'h001234)));
    cart_rd_n = 1'b1;
    repeat (4) @(negedge clk);

    // strobe released before data returns
    base = req_total;
    cart_addr = 22'h000400;
    @(negedge clk);
    cart_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    cart_rd_n = 1'b1;
    repeat (20) @(negedge clk);
    check(req_total - base == 1, "R10 early release", req_total - base, 1);
    check(!data_drive, "R7 early release", 32'(data_drive), 0);
    do_read(22'h000401, ext_word(22'h000401), 1'b0, "R10 next read");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule